// File: doc/BRIEF.md
# Banked Test-Register Access Unit

This block hangs off a plain management register port of the kind a serial management slave exposes. It owns four directly addressed 16-bit registers: a test control register, two read-data registers and a write-data register. Through them, software reaches hidden banks of internal 16-bit registers that are not visible on the port. Bank 0 holds analog and DSP tuning words, and bank 3 holds built-in self-test and fractional clock settings. Banks 1 and 2 are not implemented.

The hidden banks stay locked until the control register receives a fixed four-write toggle pattern. Once open, one control word carries the whole request: the command bits, the bank, the read address and the write address. A write command copies the write-data register into the selected hidden word. A read command loads read-data register 1 from the selected hidden word. Writing zero to the control register locks the banks again.

The unlock tracker is a state machine with these states:
- ST_LOCKED. The banks are closed.
- ST_ZERO_A. The first zero has been seen.
- ST_TM_A. The first test-mode word has been seen.
- ST_ZERO_B. The second zero has been seen.
- ST_OPEN. The banks are open.

Only control-register writes move the tracker. These are its transitions:

| From | Control write | To |
|---|---|---|
| ST_LOCKED | zero | ST_ZERO_A |
| ST_ZERO_A | test-mode word | ST_TM_A |
| ST_TM_A | zero | ST_ZERO_B |
| ST_ZERO_B | test-mode word | ST_OPEN |
| ST_ZERO_A or ST_ZERO_B | zero | ST_ZERO_A |
| ST_ZERO_A, ST_TM_A or ST_ZERO_B | any other value | ST_LOCKED |
| ST_OPEN | zero | ST_ZERO_A, which relocks the banks |
| ST_OPEN | any non-zero value | ST_OPEN |

Top module: `tba_test_access`

## Requirements
- R1: The direct registers are selected by the 5-bit port address, and all four reset to 0.
  - 0x14 is the control register. A read returns the last value written to it.
  - 0x15 is read-data register 1.
  - 0x16 is read-data register 2.
  - 0x17 is the write-data register. A read returns the last value written to it.
  - Any other address reads 0.
- R2: The control word is decoded as follows:
  - bit 15 is the read command;
  - bit 14 is the write command;
  - bits 12:11 select the bank;
  - bit 10 is the test-mode bit;
  - bits 9:5 are the read address;
  - bits 4:0 are the write address.
- R3: The banks open only after four consecutive control writes of 0x0000, 0x0400, 0x0000, 0x0400. Writes to other direct registers do not disturb the sequence.
- R4: A control write that does not fit the sequence returns the tracker to ST_LOCKED. A zero write during the sequence restarts it at its first step.
- R5: Writing 0x0000 to the control register while open relocks the banks. A new full sequence is then needed before any command acts.
- R6: While open, a control write with bit 14 and bit 10 set copies the write-data register into the hidden word at the selected bank and write address.
- R7: While open, a control write with bit 15 and bit 10 set, and bit 14 clear, loads read-data register 1 from the selected bank and read address. The new value is readable from the cycle after the write.
- R8: Commands have no effect in these cases: while the banks are locked, and when bit 10 is clear.
- R9: When bit 15 and bit 14 are both set, only the write is performed, and read-data register 1 keeps its value.
- R10: Writes to banks 1 and 2 are dropped, and reads from them return 0.
- R11: Read-data register 2 always reads 0. Port writes to either read-data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | 5 | Register port address |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Register port read data for reg_addr (combinational) |

## Verification
The bench sweeps every address of all four banks, writing and then reading back with expected words computed arithmetically. A design that decoded a field at the wrong position, or that stored into banks 1 or 2, would return a word in the wrong place or a non-zero word. It also sends commands while the banks are locked, and after an unlock sequence broken by a stray word; a tracker that ignored the break or opened too early would let those writes land. It re-issues commands after a closing zero and with the test-mode bit clear, which catches a design that stays open or ignores bit 10. It sends a command with both command bits set, which shows up a design that lets the read overwrite read-data register 1.

// File: rtl/tba_pkg.sv
package tba_pkg;
    localparam int DATA_W     = 16;
    localparam int PORT_AW    = 5;
    localparam int CMD_RD_BIT = 15;
    localparam int CMD_WR_BIT = 14;
    localparam int BANK_LO    = 11;
    localparam int TM_BIT     = 10;
    localparam int RADDR_LO   = 5;
    localparam int WADDR_LO   = 0;

    localparam logic [PORT_AW-1:0] A_CTRL = 5'h14;
    localparam logic [PORT_AW-1:0] A_RD1  = 5'h15;
    localparam logic [PORT_AW-1:0] A_RD2  = 5'h16;
    localparam logic [PORT_AW-1:0] A_WDAT = 5'h17;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_ZERO_A,
        ST_TM_A,
        ST_ZERO_B,
        ST_OPEN
    } unlock_state_e;
endpackage

// File: rtl/tba_unlock_fsm.sv
module tba_unlock_fsm
    import tba_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic              unlocked
);
    localparam logic [DATA_W-1:0] TM_WORD = DATA_W'(1) << TM_BIT;

    unlock_state_e state_q, state_d;
    logic is_zero, is_tm;

    assign is_zero = (ctrl_wdata == '0);
    assign is_tm   = (ctrl_wdata == TM_WORD);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            unique case (state_q)
                ST_LOCKED: state_d = is_zero ? ST_ZERO_A : ST_LOCKED;
                ST_ZERO_A: state_d = is_tm ? ST_TM_A : (is_zero ? ST_ZERO_A : ST_LOCKED);
                ST_TM_A:   state_d = is_zero ? ST_ZERO_B : ST_LOCKED;
                ST_ZERO_B: state_d = is_tm ? ST_OPEN : (is_zero ? ST_ZERO_A : ST_LOCKED);
                ST_OPEN:   state_d = is_zero ? ST_ZERO_A : ST_OPEN;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    always_comb begin
        unlocked = (state_q == ST_OPEN);
    end

    // R3: entering ST_OPEN must follow a control write of the test-mode word
    assert_unlock_last_tm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
            ($past(ctrl_we) && $past(ctrl_wdata) == TM_WORD));

    // R5: a zero control write always leaves the banks closed
    assert_zero_relocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata == '0) |=> !unlocked);
endmodule

// File: rtl/tba_bank_store.sv
module tba_bank_store #(
    parameter int          DATA_W    = 16,
    parameter int          NUM_BANKS = 4,
    parameter int          REGS      = 32,
    parameter logic [3:0]  IMPL_MASK = 4'b1001,
    localparam int         BW        = $clog2(NUM_BANKS),
    localparam int         AW        = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BW-1:0]     wbank,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BW-1:0]     rbank,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (IMPL_MASK[b]) begin : g_impl
            logic [DATA_W-1:0] mem_q [REGS];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < REGS; i++) mem_q[i] <= '0;
                end else if (we && wbank == BW'(b)) begin
                    mem_q[waddr] <= wdata;
                end
            end
            assign bank_rd[b] = mem_q[raddr];
        end else begin : g_empty
            assign bank_rd[b] = '0;
        end
    end

    assign rdata = bank_rd[rbank];

    // R10: unimplemented banks always read as zero
    assert_empty_bank_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!IMPL_MASK[rbank]) |-> (rdata == '0));
endmodule

// File: rtl/tba_test_access.sv
module tba_test_access
    import tba_pkg::*;
#(
    parameter int         NUM_BANKS = 4,
    parameter int         REGS      = 32,
    parameter logic [3:0] IMPL_MASK = 4'b1001,
    localparam int        BW        = $clog2(NUM_BANKS),
    localparam int        AW        = $clog2(REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [PORT_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    logic [DATA_W-1:0] ctrl_q, wdat_q, rd1_q;
    logic              ctrl_we, unlocked, cmd_ok, do_commit, do_load;
    logic [BW-1:0]     sel_bank;
    logic [AW-1:0]     sel_raddr, sel_waddr;
    logic [DATA_W-1:0] bank_rdata;

    assign ctrl_we   = reg_wr_en && (reg_addr == A_CTRL);
    assign sel_bank  = reg_wdata[BANK_LO +: BW];
    assign sel_raddr = reg_wdata[RADDR_LO +: AW];
    assign sel_waddr = reg_wdata[WADDR_LO +: AW];
    assign cmd_ok    = ctrl_we && unlocked && reg_wdata[TM_BIT];
    assign do_commit = cmd_ok && reg_wdata[CMD_WR_BIT];
    assign do_load   = cmd_ok && reg_wdata[CMD_RD_BIT] && !reg_wdata[CMD_WR_BIT];

    tba_unlock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (reg_wdata),
        .unlocked   (unlocked)
    );

    tba_bank_store #(
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .REGS      (REGS),
        .IMPL_MASK (IMPL_MASK)
    ) u_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_commit),
        .wbank (sel_bank),
        .waddr (sel_waddr),
        .wdata (wdat_q),
        .rbank (sel_bank),
        .raddr (sel_raddr),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wdat_q <= '0;
            rd1_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= reg_wdata;
            if (reg_wr_en && reg_addr == A_WDAT) wdat_q <= reg_wdata;
            if (do_load) rd1_q <= bank_rdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_RD1:   reg_rdata = rd1_q;
            A_WDAT:  reg_rdata = wdat_q;
            default: reg_rdata = '0;
        endcase
    end

    // R8: a control write while locked leaves read-data register 1 untouched
    assert_locked_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !unlocked) |=> $stable(rd1_q));

    // R9: both command bits set means read-data register 1 keeps its value
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && reg_wdata[CMD_RD_BIT] && reg_wdata[CMD_WR_BIT]) |=> $stable(rd1_q));

    // R11: read-data register 2 reads zero
    assert_rd2_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RD2) |-> (reg_rdata == '0));
endmodule

// File: tb/tba_test_access_tb.sv
`timescale 1ns/1ps
module tba_test_access_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    int checks = 0;
    int errors = 0;
    logic [15:0] model [4][32];

    always #2.5 clk = ~clk;

    tba_test_access u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [15:0] pattern(int b, int a, int salt);
        return 16'((b + 1) * 16'h0F31 ^ (a * 16'h0107) ^ 16'hA5A5 ^ salt);
    endfunction

    function automatic logic [15:0] cw(bit rd, bit wr, int bank, bit tm, int ra, int wa);
        return {rd, wr, 1'b0, 2'(bank), tm, 5'(ra), 5'(wa)};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic unlock();
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
    endtask

    task automatic hidden_read(int b, int a, output logic [15:0] d);
        unlock();
        reg_wr(5'h14, cw(1, 0, b, 1, a, 0));
        reg_rd(5'h15, d);
        reg_wr(5'h14, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) model[b][a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of the direct registers
        reg_rd(5'h14, v); check("R1 ctrl reset", v, 16'h0);
        reg_rd(5'h15, v); check("R1 rd1 reset", v, 16'h0);
        reg_rd(5'h16, v); check("R1 rd2 reset", v, 16'h0);
        reg_rd(5'h17, v); check("R1 wdat reset", v, 16'h0);
        reg_wr(5'h17, 16'h1234);
        reg_rd(5'h17, v); check("R1 wdat readback", v, 16'h1234);
        reg_wr(5'h03, 16'hFFFF);
        reg_rd(5'h03, v); check("R1 unmapped reads 0", v, 16'h0);

        // R8: write command while locked must not land
        reg_wr(5'h17, 16'hBEEF);
        reg_wr(5'h14, cw(0, 1, 0, 1, 0, 5));
        reg_rd(5'h14, v); check("R1 ctrl readback", v, cw(0, 1, 0, 1, 0, 5));

        // R11: port writes to read-data registers ignored
        reg_wr(5'h15, 16'h7777); reg_wr(5'h16, 16'h8888);
        reg_rd(5'h15, v); check("R11 rd1 write ignored", v, 16'h0);
        reg_rd(5'h16, v); check("R11 rd2 write ignored", v, 16'h0);

        // R6, R10, R2: write sweep over all banks and addresses
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) begin
                unlock();
                reg_wr(5'h17, pattern(b, a, 0));
                reg_wr(5'h14, cw(0, 1, b, 1, 31 - a, a));
                reg_wr(5'h14, 16'h0000);
                if (b == 0 || b == 3) model[b][a] = pattern(b, a, 0);
            end
        // R7, R10, R2: read sweep
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) begin
                hidden_read(b, a, v);
                check((b == 1 || b == 2) ? "R10 empty bank" : "R7 R6 sweep", v, model[b][a]);
            end
        reg_rd(5'h16, v); check("R11 rd2 stays 0", v, 16'h0);

        // R4: broken sequence, then command must be ignored
        reg_wr(5'h17, 16'h4444);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, 16'h0401);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, cw(0, 1, 3, 1, 0, 7));
        reg_wr(5'h14, 16'h0000);
        hidden_read(3, 7, v); check("R4 broken sequence", v, model[3][7]);

        // R3: write to another direct register mid-sequence does not disturb
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h17, 16'h3131);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, cw(0, 1, 0, 1, 0, 9));
        reg_wr(5'h14, 16'h0000);
        model[0][9] = 16'h3131;
        hidden_read(0, 9, v); check("R3 interleaved unlock", v, 16'h3131);

        // R4: zero restarts the sequence
        reg_wr(5'h17, 16'h5A5A);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400); reg_wr(5'h14, 16'h0000);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, 16'h0000); reg_wr(5'h14, 16'h0400);
        reg_wr(5'h14, cw(0, 1, 3, 1, 0, 2));
        reg_wr(5'h14, 16'h0000);
        model[3][2] = 16'h5A5A;
        hidden_read(3, 2, v); check("R4 zero restart", v, 16'h5A5A);

        // R5: close then command must be ignored
        reg_wr(5'h17, 16'h6B6B);
        unlock();
        reg_wr(5'h14, 16'h0000);
        reg_wr(5'h14, cw(0, 1, 0, 1, 0, 4));
        reg_wr(5'h14, 16'h0000);
        hidden_read(0, 4, v); check("R5 close relocks", v, model[0][4]);

        // R8: test-mode bit clear means no commit
        reg_wr(5'h17, 16'h7C7C);
        unlock();
        reg_wr(5'h14, cw(0, 1, 3, 0, 0, 5));
        reg_wr(5'h14, 16'h0000);
        hidden_read(3, 5, v); check("R8 tm clear", v, model[3][5]);

        // R9: both bits, write wins and rd1 keeps its value
        hidden_read(0, 1, v); check("R7 preload", v, model[0][1]);
        reg_wr(5'h17, 16'h9D9D);
        unlock();
        reg_wr(5'h14, cw(1, 1, 0, 1, 2, 6));
        reg_rd(5'h15, v); check("R9 rd1 kept", v, model[0][1]);
        reg_wr(5'h14, 16'h0000);
        model[0][6] = 16'h9D9D;
        hidden_read(0, 6, v); check("R9 write done", v, 16'h9D9D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule